// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the scan timing for a parallel RGB panel from a single system clock. An integer divisor turns the system clock into a pixel-rate enable and a panel clock whose sampling edge is selectable. Two counters walk each line and each frame. From them the block derives horizontal and vertical sync, the data-enable window and pixel coordinates that count from zero inside the visible area.

Software sets the geometry through a simple write port. The settings are the total line and frame lengths, independent sync-on and sync-off positions, and the start and size of the visible region on each axis. Geometry writes go to a staging copy. The counters read a working copy, which is refreshed only when a frame wraps or while the pixel clock is stopped, so a frame never mixes two settings. A consistency flag reports a staged geometry whose visible region plus its offset does not fit inside the total.

A write of divisor zero stops the scan. A non-zero divisor starts clocking pixels out from the first pixel of a frame. A one-cycle frame-start strobe marks each wrap. A display-buffer swap request waits for that strobe and is acknowledged in the same cycle as it. A panel enable level is taken from bit 7 of a general-purpose register.

Top module: `lcdt_timing_gen`

## Requirements
- R1: When register 10 (divisor) holds 0, pix_ce never pulses, hsync, vsync and de stay low, and the line and frame counters are held at zero. Writing a non-zero divisor restarts the scan at pixel (0,0) of a frame.
- R2: With divisor N (register 10, bits 7:0, N ≥ 1), pix_ce pulses for one system cycle every N system cycles.
- R3: For N ≥ 2, pclk_out equals the polarity bit (register 11, bit 0) in the system cycle right after each pix_ce, and equals its inverse in the pix_ce cycle. When stopped, pclk_out rests at the polarity bit.
- R4: The pixel position h runs from 0 to line_total−1 (register 0) and the line position v from 0 to frame_total−1 (register 5), with v advancing when h wraps. hsync is high for hs_on ≤ h < hs_off (registers 1 and 2). vsync is high for vs_on ≤ v < vs_off (registers 6 and 7).
- R5: de is high exactly when h_start ≤ h < h_start+h_len and v_start ≤ v < v_start+v_len (registers 3, 4, 8 and 9).
- R6: While de is high, px_x = h−h_start and px_y = v−v_start. Both outputs are 0 otherwise.
- R7: frame_start is a one-cycle pulse in the first system cycle in which the counters show (0,0) after the last pixel of a frame. It pulses once per completed frame.
- R8: Geometry writes (registers 0–9) made while running take effect at the next frame start. Writes made while stopped take effect at restart.
- R9: Writing register 13 with bit 0 set requests a buffer swap. swap_done pulses only together with frame_start: once, at the first frame_start after the request.
- R10: disp_en follows bit 7 of the last value written to register 12.
- R11: cfg_err is high when the staged geometry has h_start+h_len ≥ line_total or v_start+v_len ≥ frame_total, and low otherwise.
- R12: After reset the scan is stopped, all strobes and sync outputs are low, disp_en is 0, and a valid 1024x600 geometry (line 1344, frame 635) is staged, so cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 11 | Register write value |
| pix_ce | output | 1 | One-cycle pixel enable |
| pclk_out | output | 1 | Panel pixel clock with selected polarity |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable (visible area) |
| px_x | output | 11 | Column inside the visible area |
| px_y | output | 11 | Row inside the visible area |
| frame_start | output | 1 | Frame wrap strobe |
| swap_done | output | 1 | Buffer swap applied at this frame start |
| disp_en | output | 1 | Panel enable level |
| cfg_err | output | 1 | Staged geometry inconsistent |

## Verification
The scan is tried with random small geometries, each paired with a random divisor from 1 to 4 and a random polarity. Sync windows start anywhere, including position zero and runs that reach the last pixel, which separates off-by-one errors in the window compares from errors in counter wrapping. Divisor 1 and divisor 2 or more are both covered, so the back-to-back enable case is told apart from the case that shapes the panel clock. A directed run rewrites the line length and the vsync start mid-frame and requests a swap at the same point, which shows whether changes are deferred to the frame wrap. Directed writes just over the offset limit on each axis exercise the consistency flag.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int unsigned CW = 11;   // coordinate and geometry width
    localparam int unsigned DW = 8;    // divisor width
    localparam int unsigned AW = 4;    // register index width

    typedef logic [CW-1:0] coord_t;

    typedef struct packed {
        coord_t h_total;
        coord_t hs_on;
        coord_t hs_off;
        coord_t h_start;
        coord_t h_len;
        coord_t v_total;
        coord_t vs_on;
        coord_t vs_off;
        coord_t v_start;
        coord_t v_len;
    } geom_t;

    typedef enum logic [AW-1:0] {
        A_HTOT   = 4'd0,
        A_HSON   = 4'd1,
        A_HSOFF  = 4'd2,
        A_HSTART = 4'd3,
        A_HLEN   = 4'd4,
        A_VTOT   = 4'd5,
        A_VSON   = 4'd6,
        A_VSOFF  = 4'd7,
        A_VSTART = 4'd8,
        A_VLEN   = 4'd9,
        A_DIV    = 4'd10,
        A_POL    = 4'd11,
        A_GPIO   = 4'd12,
        A_SWAP   = 4'd13
    } addr_e;

    localparam geom_t GEOM_RESET = '{
        h_total: CW'(1344), hs_on: CW'(0),   hs_off: CW'(100),
        h_start: CW'(160),  h_len: CW'(1024),
        v_total: CW'(635),  vs_on: CW'(0),   vs_off: CW'(10),
        v_start: CW'(23),   v_len: CW'(600)
    };

    // pos inside [lo, lo+len)
    function automatic logic in_span(coord_t pos, coord_t lo, coord_t len);
        return ({1'b0, pos} >= {1'b0, lo}) &&
               ({1'b0, pos} < ({1'b0, lo} + {1'b0, len}));
    endfunction

    // pos inside [on, off)
    function automatic logic in_range(coord_t pos, coord_t on, coord_t off);
        return (pos >= on) && (pos < off);
    endfunction

    // visible region does not leave room before the total
    function automatic logic overrun(coord_t lo, coord_t len, coord_t total);
        return ({1'b0, lo} + {1'b0, len}) >= {1'b0, total};
    endfunction

    // position is the last one before wrap
    function automatic logic is_last(coord_t pos, coord_t total);
        return ({1'b0, pos} + (CW+1)'(1)) >= {1'b0, total};
    endfunction

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          load_live,
    input  logic          frame_wrap,
    output geom_t         live,
    output logic [DW-1:0] div,
    output logic          pol,
    output logic          disp,
    output logic          cfg_err,
    output logic          swap_done
);

    geom_t staged;
    logic  swap_pend;
    logic  swap_req;

    assign swap_req = wr_en && (addr_e'(wr_addr) == A_SWAP) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= GEOM_RESET;
            div    <= '0;
            pol    <= 1'b0;
            disp   <= 1'b0;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                A_HTOT:   staged.h_total <= wr_data;
                A_HSON:   staged.hs_on   <= wr_data;
                A_HSOFF:  staged.hs_off  <= wr_data;
                A_HSTART: staged.h_start <= wr_data;
                A_HLEN:   staged.h_len   <= wr_data;
                A_VTOT:   staged.v_total <= wr_data;
                A_VSON:   staged.vs_on   <= wr_data;
                A_VSOFF:  staged.vs_off  <= wr_data;
                A_VSTART: staged.v_start <= wr_data;
                A_VLEN:   staged.v_len   <= wr_data;
                A_DIV:    div            <= wr_data[DW-1:0];
                A_POL:    pol            <= wr_data[0];
                A_GPIO:   disp           <= wr_data[7];
                default:  ;
            endcase
        end
    end

    // working copy follows the staged copy only at safe points
    always_ff @(posedge clk) begin
        if (rst)            live <= GEOM_RESET;
        else if (load_live) live <= staged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swap_pend <= 1'b0;
            swap_done <= 1'b0;
        end else if (frame_wrap) begin
            swap_done <= swap_pend;
            swap_pend <= swap_req;
        end else begin
            swap_done <= 1'b0;
            swap_pend <= swap_pend | swap_req;
        end
    end

    assign cfg_err = overrun(staged.h_start, staged.h_len, staged.h_total) ||
                     overrun(staged.v_start, staged.v_len, staged.v_total);

    a_r8_live_frozen: assert property (@(posedge clk) disable iff (rst)
        !load_live |=> $stable(live));

    a_r9_swap_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !frame_wrap |=> !swap_done);

endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div,
    input  logic          pol,
    output logic          ce,
    output logic          pclk_out
);

    logic [DW-1:0] cnt_q;
    logic          run;
    logic          last;

    assign run  = (div != '0);
    assign last = run && (({1'b0, cnt_q} + (DW+1)'(1)) >= {1'b0, div});
    assign ce   = last;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (last)    cnt_q <= '0;
        else              cnt_q <= cnt_q + DW'(1);
    end

    // first half of the pixel period at the idle level, second half inverted
    assign pclk_out = run ? ((cnt_q >= (div >> 1)) ^ pol) : pol;

    a_r1_cnt_idle: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |=> (cnt_q == '0));

    a_r3_phase_after_tick: assert property (@(posedge clk) disable iff (rst)
        (ce && div >= DW'(2)) |=>
            (pclk_out == pol || div != $past(div) || pol != $past(pol)));

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   ce,
    input  geom_t  live,
    output logic   hsync,
    output logic   vsync,
    output logic   de,
    output coord_t x,
    output coord_t y,
    output logic   frame_wrap,
    output logic   frame_start
);

    coord_t h_q, v_q;
    logic   h_last, v_last;
    logic   h_act, v_act;

    assign h_last     = is_last(h_q, live.h_total);
    assign v_last     = is_last(v_q, live.v_total);
    assign frame_wrap = ce && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            h_q         <= '0;
            v_q         <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= frame_wrap;
            if (ce) begin
                if (h_last) begin
                    h_q <= '0;
                    v_q <= v_last ? '0 : v_q + CW'(1);
                end else begin
                    h_q <= h_q + CW'(1);
                end
            end
        end
    end

    assign h_act = in_span(h_q, live.h_start, live.h_len);
    assign v_act = in_span(v_q, live.v_start, live.v_len);

    assign hsync = run && in_range(h_q, live.hs_on, live.hs_off);
    assign vsync = run && in_range(v_q, live.vs_on, live.vs_off);
    assign de    = run && h_act && v_act;
    assign x     = de ? (h_q - live.h_start) : '0;
    assign y     = de ? (v_q - live.v_start) : '0;

    a_r1_hold_origin: assert property (@(posedge clk) disable iff (rst)
        !run |=> (h_q == '0 && v_q == '0));

    a_r7_strobe_at_origin: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (h_q == '0 && v_q == '0));

    a_r4_h_in_line: assert property (@(posedge clk) disable iff (rst)
        (run && live.h_total != '0) |-> (h_q < live.h_total));

    a_r4_v_in_frame: assert property (@(posedge clk) disable iff (rst)
        (run && live.v_total != '0) |-> (v_q < live.v_total));

endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          pix_ce,
    output logic          pclk_out,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] px_x,
    output logic [CW-1:0] px_y,
    output logic          frame_start,
    output logic          swap_done,
    output logic          disp_en,
    output logic          cfg_err
);

    geom_t         live;
    logic [DW-1:0] div;
    logic          pol;
    logic          run;
    logic          frame_wrap;
    logic          load_live;

    assign run       = (div != '0);
    assign load_live = !run || frame_wrap;

    lcdt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_live  (load_live),
        .frame_wrap (frame_wrap),
        .live       (live),
        .div        (div),
        .pol        (pol),
        .disp       (disp_en),
        .cfg_err    (cfg_err),
        .swap_done  (swap_done)
    );

    lcdt_pixdiv u_div (
        .clk      (clk),
        .rst      (rst),
        .div      (div),
        .pol      (pol),
        .ce       (pix_ce),
        .pclk_out (pclk_out)
    );

    lcdt_scan u_scan (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .ce          (pix_ce),
        .live        (live),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .x           (px_x),
        .y           (px_y),
        .frame_wrap  (frame_wrap),
        .frame_start (frame_start)
    );

endmodule

// File: tb/lcdt_timing_gen_test.sv
module lcdt_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        pix_ce, pclk_out, hsync, vsync, de;
    logic [10:0] px_x, px_y;
    logic        frame_start, swap_done, disp_en, cfg_err;

    always #5 clk = ~clk;

    lcdt_timing_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_ce(pix_ce), .pclk_out(pclk_out), .hsync(hsync), .vsync(vsync), .de(de),
        .px_x(px_x), .px_y(px_y), .frame_start(frame_start), .swap_done(swap_done),
        .disp_en(disp_en), .cfg_err(cfg_err)
    );

    int vec = 0;
    int bad = 0;

    // bench-side model of the register state and scan position
    int sh[10];
    int cur[10];
    int mdiv = 0;
    bit mpol = 0;
    int mh = 0, mv = 0;
    int wraps = 0, frames_seen = 0, swaps_seen = 0;
    bit first = 1, prev_ce = 0, pend_swap = 0;
    int cyc = 0, last_ce = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 11'(d);
        if (a < 10) sh[a] = d;
        if (a == 10) begin
            mdiv = d & 8'hFF;
            if (mdiv != 0) begin
                mh = 0; mv = 0; cur = sh; first = 1; prev_ce = 0;
                wraps = 0; frames_seen = 0; swaps_seen = 0;
            end
        end
        if (a == 11) mpol = d[0];
        if (a == 13 && d[0]) pend_swap = 1;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    // monitor: runs at the falling edge, before any input change
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (mdiv == 0)
                chk(!pix_ce && !hsync && !vsync && !de, "R1 stopped outputs",
                    int'({pix_ce, hsync, vsync, de}), 0);
            if (frame_start) begin
                chk(mh == 0 && mv == 0, "R7 strobe at origin", mh * 1000 + mv, 0);
                frames_seen++;
                chk(swap_done == pend_swap, "R9 swap at frame start", int'(swap_done), int'(pend_swap));
                if (swap_done) swaps_seen++;
                pend_swap = 0;
            end else if (swap_done) begin
                chk(0, "R9 swap outside frame start", 1, 0);
            end
            if (mdiv >= 2 && prev_ce)
                chk(pclk_out == mpol, "R3 pclk after tick", int'(pclk_out), int'(mpol));
            if (mdiv >= 2 && pix_ce)
                chk(pclk_out == !mpol, "R3 pclk at tick", int'(pclk_out), int'(!mpol));
            if (pix_ce && mdiv != 0) begin
                bit hs_e, vs_e, de_e;
                int xe, ye;
                if (!first) chk(cyc - last_ce == mdiv, "R2 tick spacing", cyc - last_ce, mdiv);
                first = 0;
                last_ce = cyc;
                hs_e = (mh >= cur[1]) && (mh < cur[2]);
                vs_e = (mv >= cur[6]) && (mv < cur[7]);
                de_e = (mh >= cur[3]) && (mh < cur[3] + cur[4]) &&
                       (mv >= cur[8]) && (mv < cur[8] + cur[9]);
                xe = de_e ? mh - cur[3] : 0;
                ye = de_e ? mv - cur[8] : 0;
                chk(hsync == hs_e, "R4 hsync", int'(hsync), int'(hs_e));
                chk(vsync == vs_e, "R4 vsync", int'(vsync), int'(vs_e));
                chk(de == de_e, "R5 de", int'(de), int'(de_e));
                chk(int'(px_x) == xe, "R6 px_x", int'(px_x), xe);
                chk(int'(px_y) == ye, "R6 px_y", int'(px_y), ye);
                if (mh + 1 >= cur[0]) begin
                    mh = 0;
                    if (mv + 1 >= cur[5]) begin
                        mv = 0; wraps++; cur = sh;
                    end else mv++;
                end else mh++;
            end
            prev_ce = pix_ce;
        end
    end

    task automatic rand_geom();
        int ht, vt, hl, vl, hs, vs;
        ht = 8 + int'($urandom % 13);
        vt = 4 + int'($urandom % 5);
        hl = 1 + int'($urandom % (ht - 2));
        vl = 1 + int'($urandom % (vt - 2));
        hs = int'($urandom % ht);
        vs = int'($urandom % vt);
        wr(0, ht);
        wr(1, hs);
        wr(2, hs + 1 + int'($urandom % (ht - hs)));
        wr(3, int'($urandom % (ht - hl)));
        wr(4, hl);
        wr(5, vt);
        wr(6, vs);
        wr(7, vs + 1 + int'($urandom % (vt - vs)));
        wr(8, int'($urandom % (vt - vl)));
        wr(9, vl);
    endtask

    task automatic stop_and_count();
        wr(10, 0);
        repeat (6) @(negedge clk);
        chk(frames_seen == wraps, "R7 one strobe per frame", frames_seen, wraps);
    endtask

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd1234));
        sh = '{1344, 0, 100, 160, 1024, 635, 0, 10, 23, 600};
        cur = sh;
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!pix_ce && !hsync && !vsync && !de && !frame_start && !swap_done,
            "R12 reset strobes", int'({pix_ce, hsync, vsync, de, frame_start, swap_done}), 0);
        chk(!disp_en, "R12 reset disp", int'(disp_en), 0);
        chk(!cfg_err, "R12 reset geometry valid", int'(cfg_err), 0);
        chk(!pclk_out, "R3 idle pclk level", int'(pclk_out), 0);

        wr(12, 'h80);
        chk(disp_en, "R10 disp set", int'(disp_en), 1);
        wr(12, 'h7F);
        chk(!disp_en, "R10 disp clear", int'(disp_en), 0);

        wr(3, 320);
        chk(cfg_err, "R11 h offset at limit", int'(cfg_err), 1);
        wr(3, 319);
        chk(!cfg_err, "R11 h offset below limit", int'(cfg_err), 0);
        wr(8, 35);
        chk(cfg_err, "R11 v offset at limit", int'(cfg_err), 1);
        wr(8, 23);
        chk(!cfg_err, "R11 v offset restored", int'(cfg_err), 0);

        // random geometries, divisors and polarities
        for (int k = 0; k < 10; k++) begin
            int n;
            rand_geom();
            wr(11, int'($urandom % 2));
            chk(!cfg_err, "R11 valid random geometry", int'(cfg_err), 0);
            n = (k < 2) ? k + 1 : 1 + int'($urandom % 4);
            wr(10, n);
            repeat ((2 * sh[0] * sh[5] + 4) * n) @(negedge clk);
            stop_and_count();
        end

        // deferred geometry change and swap, requested mid-frame (R8, R9)
        rand_geom();
        wr(11, 1);
        wr(10, 2);
        do begin
            @(negedge clk); #1;
        end while (!(mv == 1 && mh == 0));
        wr(0, sh[0] + 3);
        wr(6, 0);
        wr(13, 1);
        repeat ((3 * (sh[0]) * sh[5] + 4) * 2) @(negedge clk);
        chk(swaps_seen == 1, "R9 single swap", swaps_seen, 1);
        chk(wraps >= 2, "R8 frames after change", wraps, 2);
        stop_and_count();

        // restart from stop begins at origin (R1) with divisor 3
        wr(10, 3);
        repeat ((sh[0] * sh[5] + 4) * 3) @(negedge clk);
        stop_and_count();

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule